// File: doc/BRIEF.md
# Packed Floating-Point Minimum Unit

This block takes two packed vectors of equal width and returns, lane by lane, the smaller of each pair of floating-point values. A two-bit format code splits the vector into half, single or double precision lanes. Every lane is computed in parallel, and the full result is captured in a register one clock after the input strobe.

Two mode inputs choose how special values are handled. In standard mode, the ordering places negative zero below positive zero, and a NaN input is propagated as a quiet NaN, or as the canonical default NaN when that option is set. In alternate mode, a pair of zeros of any signs, or any NaN input, makes the lane return the second operand bit for bit. A sticky-free invalid flag goes with each result and reports a signaling NaN in any lane. A format code of zero is rejected: it raises an error strobe and leaves the result unchanged.

Top module: `pkd_fmin`

## Requirements
- R1: `fmt` selects the lane width: 01 gives 16-bit lanes (5 exponent bits, 10 fraction bits), 10 gives 32-bit lanes (8/23), 11 gives 64-bit lanes (11/52). There are W/lane-width lanes, lane i occupies bits [i*lw +: lw], and each lane is computed only from its own two inputs.
- R2: When `in_vld` is high with a legal `fmt`, `out_vld` is high in the next cycle and `res` holds the lane-wise result of that input.
- R3: When `in_vld` is high with `fmt` = 00, `fmt_err` is high in the next cycle, `out_vld` and `inv` stay low, and `res` keeps its previous value.
- R4: With `alt` low and no NaN in a lane, the lane result is the numerically smaller operand, with -0 ordered below +0 and subnormals compared exactly as encoded.
- R5: With `alt` low and `dnan` low, a NaN in a lane returns a NaN picked in this order: signaling NaN in `a`, signaling NaN in `b`, quiet NaN in `a`, quiet NaN in `b`; the picked value has its top fraction bit set.
- R6: With `alt` low and `dnan` high, a NaN in a lane returns the default NaN: sign 0, exponent all ones, top fraction bit 1, other fraction bits 0.
- R7: With `alt` high, when both lane inputs are zeros of any sign, the lane returns `b` unchanged.
- R8: With `alt` high, a NaN in either lane input returns `b` unchanged, whatever `dnan` is.
- R9: `inv` is high together with `out_vld` exactly when some lane of `a` or `b` holds a signaling NaN (exponent all ones, top fraction bit 0, fraction nonzero), in either mode.
- R10: In a cycle after `in_vld` was low, `out_vld`, `fmt_err` and `inv` are low and `res` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input strobe |
| fmt | input | 2 | Lane format code |
| alt | input | 1 | Alternate special-value handling |
| dnan | input | 1 | Return default NaN in standard mode |
| a | input | W | First operand vector |
| b | input | W | Second operand vector |
| out_vld | output | 1 | Result valid |
| res | output | W | Registered result vector |
| inv | output | 1 | Signaling NaN seen in the last accepted input |
| fmt_err | output | 1 | Last strobe carried format code 00 |

## Verification
The invalid flag and the NaN selection of R5 fall in the same cycle whenever a vector holds a signaling NaN in one lane and ordinary values in others; random lanes drawn from a pool heavy in zeros, NaNs, infinities and subnormals provoke this mix, and the bench then judges the whole result vector and the flag against its own model in that one sample. An illegal format code also arrives right after a legal one, so that the error strobe and the held result are checked in the cycle that would otherwise carry the next result.

// File: rtl/pkd_fmin.sv
module pkd_fmin #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [1:0]   fmt,
  input  logic         alt,
  input  logic         dnan,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_vld,
  output logic [W-1:0] res,
  output logic         inv,
  output logic         fmt_err
);

  // bit 64 = signaling NaN seen, bits 63:0 = lane result (zero extended)
  function automatic logic [64:0] lane_op(input logic [63:0] x, input logic [63:0] y,
                                          input logic [1:0] sz, input logic am, input logic dm);
    int lw, fw;
    logic [63:0] fm, em, qb, mx, my, mn, r;
    logic nx, ny, sx, sy, zx, zy, gx, gy, lt;
    lw = 32'd8 << sz;
    fw = (sz == 2'd1) ? 10 : (sz == 2'd2) ? 23 : 52;
    fm = (64'd1 << fw) - 64'd1;
    em = ((64'd1 << (lw - 1)) - 64'd1) & ~fm;
    qb = 64'd1 << (fw - 1);
    nx = ((x & em) == em) && ((x & fm) != 64'd0);
    ny = ((y & em) == em) && ((y & fm) != 64'd0);
    sx = nx && ((x & qb) == 64'd0);
    sy = ny && ((y & qb) == 64'd0);
    mx = x & (em | fm);
    my = y & (em | fm);
    zx = (mx == 64'd0);
    zy = (my == 64'd0);
    gx = (x & (64'd1 << (lw - 1))) != 64'd0;
    gy = (y & (64'd1 << (lw - 1))) != 64'd0;
    if (gx != gy) lt = gx;
    else if (!gx) lt = mx < my;
    else          lt = mx > my;
    mn = lt ? x : y;
    if (am) begin
      r = (nx || ny || (zx && zy)) ? y : mn;
    end else if (nx || ny) begin
      if (dm) r = em | qb;
      else    r = (sx ? x : sy ? y : nx ? x : y) | qb;
    end else begin
      r = mn;
    end
    return {sx || sy, r};
  endfunction

  logic [W-1:0] fmt_res [1:3];
  logic [3:1]   fmt_sn;

  for (genvar f = 1; f < 4; f++) begin : g_fmt
    localparam int LW = 8 << f;
    localparam int NL = W / LW;
    logic [NL-1:0] sn;
    for (genvar i = 0; i < NL; i++) begin : g_lane
      logic [64:0] t;
      logic        lane_unused;
      assign t = lane_op(64'(a[LW*i +: LW]), 64'(b[LW*i +: LW]), 2'(f), alt, dnan);
      assign fmt_res[f][LW*i +: LW] = t[LW-1:0];
      assign sn[i] = t[64];
      assign lane_unused = ^(t[63:0] >> LW);
    end
    assign fmt_sn[f] = |sn;
  end

  wire legal = fmt != 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      fmt_err <= 1'b0;
      inv     <= 1'b0;
      res     <= '0;
    end else begin
      out_vld <= in_vld && legal;
      fmt_err <= in_vld && !legal;
      inv     <= in_vld && legal && fmt_sn[legal ? fmt : 2'd1];
      if (in_vld && legal) res <= fmt_res[fmt];
    end
  end

  // R2
  legal_gives_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && fmt != 2'd0) |=> (out_vld && !fmt_err));

  // R3
  bad_fmt_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && fmt == 2'd0) |=> (fmt_err && !out_vld && !inv && $stable(res)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && !fmt_err && !inv && $stable(res)));

  // R9
  inv_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv |-> out_vld);

  // R3
  err_vld_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_vld && fmt_err));

endmodule

// File: tb/pkd_fmin_bench.sv
module pkd_fmin_bench;
  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic [1:0]   fmt = 2'd1;
  logic         alt = 1'b0;
  logic         dnan = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         out_vld;
  logic [W-1:0] res;
  logic         inv;
  logic         fmt_err;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] held = '0;

  always #5 clk = ~clk;

  pkd_fmin #(.W(W)) u_pkd_fmin (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .fmt(fmt), .alt(alt), .dnan(dnan),
    .a(a), .b(b), .out_vld(out_vld), .res(res), .inv(inv), .fmt_err(fmt_err)
  );

  function automatic int ew_of(int lw);
    return (lw == 16) ? 5 : (lw == 32) ? 8 : 11;
  endfunction

  function automatic bit is_nan(logic [63:0] v, int lw);
    int e = ew_of(lw);
    int f = lw - 1 - e;
    logic [63:0] ex = (v >> f) & ((64'd1 << e) - 1);
    logic [63:0] fr = v & ((64'd1 << f) - 1);
    return (ex == ((64'd1 << e) - 1)) && (fr != 0);
  endfunction

  function automatic bit is_snan(logic [63:0] v, int lw);
    int f = lw - 1 - ew_of(lw);
    return is_nan(v, lw) && !v[f-1];
  endfunction

  function automatic logic [63:0] model_lane(logic [63:0] x, logic [63:0] y, int lw, bit am, bit dm);
    int f = lw - 1 - ew_of(lw);
    logic [63:0] magm = (64'd1 << (lw - 1)) - 1;
    logic [63:0] qbit = 64'd1 << (f - 1);
    logic signed [65:0] kx, ky;
    bit sgx = x[lw-1];
    bit sgy = y[lw-1];
    bit nx = is_nan(x, lw);
    bit ny = is_nan(y, lw);
    bit bothz = ((x & magm) == 0) && ((y & magm) == 0);
    kx = sgx ? -$signed({2'b0, x & magm}) : $signed({2'b0, x & magm});
    ky = sgy ? -$signed({2'b0, y & magm}) : $signed({2'b0, y & magm});
    if (am && (nx || ny || bothz)) return y;
    if (nx || ny) begin
      if (dm) return magm & ~((64'd1 << (f - 1)) - 1);
      if (is_snan(x, lw)) return x | qbit;
      if (is_snan(y, lw)) return y | qbit;
      if (nx) return x | qbit;
      return y | qbit;
    end
    if (kx < ky) return x;
    if (ky < kx) return y;
    if (sgx && !sgy) return x;
    return y;
  endfunction

  function automatic logic [63:0] pick_lane(int lw);
    int e = ew_of(lw);
    int f = lw - 1 - e;
    logic [63:0] rnd = {$urandom, $urandom};
    logic [63:0] fm = (64'd1 << f) - 1;
    logic [63:0] em = ((64'd1 << e) - 1) << f;
    logic [63:0] sg = 64'd1 << (lw - 1);
    logic [63:0] v;
    case ($urandom % 8)
      1: v = 0;
      2: v = sg;
      3: v = em | (64'd1 << (f - 1)) | (rnd & fm) | (rnd & sg);
      4: v = em | ((rnd & (fm >> 1)) | 64'd1) | (rnd & sg);
      5: v = em | (rnd & sg);
      6: v = (rnd & fm) | (rnd & sg);
      default: v = rnd & ((sg << 1) - 1);
    endcase
    if (lw < 64) v = v & ((64'd1 << lw) - 1);
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(logic [W-1:0] xa, logic [W-1:0] xb, logic [1:0] sz, bit am, bit dm, string tag);
    int lw = 8 << sz;
    logic [W-1:0] er = held;
    bit es = 0;
    bit lg = (sz != 0);
    if (lg) begin
      for (int i = 0; i < W / lw; i++) begin
        logic [63:0] la = 64'(xa >> (i * lw)) & ((lw == 64) ? '1 : ((64'd1 << lw) - 1));
        logic [63:0] lb = 64'(xb >> (i * lw)) & ((lw == 64) ? '1 : ((64'd1 << lw) - 1));
        logic [63:0] lr = model_lane(la, lb, lw, am, dm);
        for (int k = 0; k < lw; k++) er[i*lw + k] = lr[k];
        es = es | is_snan(la, lw) | is_snan(lb, lw);
      end
    end
    a = xa; b = xb; fmt = sz; alt = am; dnan = dm; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    check(res == er, tag, res, er);
    check(out_vld == lg && fmt_err == !lg, lg ? "R2 valid" : "R3 error strobe",
          W'({out_vld, fmt_err}), W'({lg, !lg}));
    check(inv == (lg && es), "R9 invalid flag", W'(inv), W'(lg && es));
    held = er;
  endtask

  function automatic logic [W-1:0] rand_vec(logic [1:0] sz);
    int lw = 8 << sz;
    logic [W-1:0] v = '0;
    for (int i = 0; i < W / lw; i++) begin
      logic [63:0] l = pick_lane(lw);
      for (int k = 0; k < lw; k++) v[i*lw + k] = l[k];
    end
    return v;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    check(out_vld == 0 && fmt_err == 0 && inv == 0 && res == '0, "R2 reset state",
          res, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 signed zeros in single precision, both orders
    run({4{32'h0000_0000}}, {4{32'h8000_0000}}, 2'd2, 0, 0, "R4 -0 below +0");
    run({4{32'h8000_0000}}, {4{32'h0000_0000}}, 2'd2, 0, 0, "R4 -0 below +0 swapped");
    // R7 alternate mode returns b for any zeros
    run({4{32'h8000_0000}}, {4{32'h0000_0000}}, 2'd2, 1, 0, "R7 zeros give b");
    // R5 signaling NaN in b beats quiet NaN in a
    run({4{32'h7FC0_0001}}, {4{32'h7F80_0002}}, 2'd2, 0, 0, "R5 NaN priority");
    // R6 default NaN in half precision
    run({8{16'h7E11}}, {8{16'h3C00}}, 2'd1, 0, 1, "R6 default NaN");
    // R8 alternate mode NaN returns b even with dnan set
    run({2{64'h7FF0_0000_0000_0001}}, {2{64'hBFF0_0000_0000_0000}}, 2'd3, 1, 1, "R8 NaN gives b");
    // R1 lanes are independent: mixed lanes in fp16
    run(128'h0001_8000_7C00_FC00_3C00_0000_BC00_0400,
        128'h0002_0000_3C00_3C00_BC00_8000_3C00_0001, 2'd1, 0, 0, "R1 fp16 lanes");
    // R3 illegal code right after a legal one
    run(rand_vec(2'd2), rand_vec(2'd2), 2'd0, 0, 0, "R3 result held");
    // R10 idle cycles
    repeat (3) begin
      @(negedge clk);
      check(!out_vld && !fmt_err && !inv && res == held, "R10 idle", res, held);
    end

    for (int n = 0; n < 400; n++) begin
      logic [1:0] sz = (($urandom % 16) == 0) ? 2'd0 : 2'(1 + $urandom % 3);
      bit am = $urandom % 2;
      bit dm = $urandom % 2;
      logic [1:0] gz = (sz == 0) ? 2'd1 : sz;
      run(rand_vec(gz), rand_vec(gz), sz, am, dm,
          (sz == 0) ? "R3 random" : am ? "R7 R8 random" : dm ? "R4 R6 random" : "R4 R5 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule